// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block handles the timing side of keeping an asynchronous DRAM alive: it does not touch the memory pins. After reset it waits out the power-on pause. It then asks the memory controller for a burst of wake-up cycles. Once those are done it asks for one refresh at a steady rate. That rate is chosen so that every row of the array is visited within its retention window. Each request is meant to be served by the controller as a CAS-before-RAS cycle. The memory's own internal counter then picks the row, so the scheduler holds no row address.

The scheduler and the controller talk through a level request and a one-cycle acknowledge. A small counter of owed refreshes lets the controller put off service while it is busy. If the owed count reaches a set limit, the retention rule counts as broken. The block then pulses an overdue flag, drops its ready output and runs the whole wake-up sequence again.

Clock rate, array organisation (11 or 12 row bits), pause length, wake-up count, safety margin and deferral limit are all parameters. The 12-bit organisation uses a 64 ms window and the 11-bit one uses 32 ms.

Top module: `dram_refresh_sched`

## Requirements
- R1: After `rst_n` is released, `ref_req` stays low and goes high on the (PAUSE_CLKS+2)-th rising clock edge. PAUSE_CLKS = POWERUP_US*CLK_KHZ/1000, and the extra two edges come from the reset synchroniser.
- R2: In the wake-up phase `ref_req` stays high without a break. `mem_ready` rises right after the edge that samples the WAKE_CYCLES-th acknowledge (8 by default), and not after fewer.
- R3: The refresh period is PERIOD_CLKS = floor(CLK_KHZ*RET_MS/2^ROW_BITS) - MARGIN_CLKS. RET_MS is 64 for ROW_BITS=12 and 32 for ROW_BITS=11. The first refresh request comes exactly PERIOD_CLKS edges after `mem_ready` rises, and one falls due every PERIOD_CLKS edges after that.
- R4: A refresh request stays high until it is acknowledged. One acknowledge, high on one clock edge, retires exactly one owed refresh.
- R5: Refreshes that are not acknowledged build up. `ref_req` stays high until every owed refresh has been acknowledged.
- R6: An acknowledge during the power-on pause, or while nothing is owed, has no effect. It does not count toward wake-up, and it does not reduce or wrap the owed count.
- R7: When a period expires with MAX_PENDING-1 refreshes already owed and no acknowledge, `overdue` pulses for one cycle. At the same time `mem_ready` drops and `ref_req` stays high, and a full WAKE_CYCLES wake-up sequence is needed before `mem_ready` rises again.
- R8: `mem_ready` is low from reset through the pause and the wake-up phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_ack | input | 1 | Controller has served one requested cycle (one-cycle pulse) |
| ref_req | output | 1 | Request for a wake-up or CAS-before-RAS refresh cycle |
| mem_ready | output | 1 | Initialisation complete, memory usable |
| overdue | output | 1 | One-cycle pulse when the deferral limit is hit |

## Verification
The first request is due on edge PAUSE_CLKS+2 after reset release. `mem_ready` changes on the edge that samples the last wake-up acknowledge. The first refresh request follows PERIOD_CLKS edges after `mem_ready` rises. A drop of `ref_req` follows on the same edge as the acknowledge that retires the last owed refresh. The bench drives inputs after the falling edge and samples outputs at the next falling edge, and it counts edges from each event to check these exact counts. The deferral walk starts at a request edge and stays well inside each period. This keeps exactly one expiry inside every waited window, and the overdue check samples a few cycles before and after the expected expiry edge.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2
  } drs_state_e;

  // Retention window in milliseconds for a given number of row address bits
  function automatic int retention_ms(input int row_bits);
    return (row_bits >= 12) ? 64 : 32;
  endfunction
endpackage

// File: rtl/drs_rst_sync.sv
module drs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/drs_timer.sv
module drs_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign tick = en && !clr && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || tick) cnt_d = '0;
    else if (en)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/drs_pend_ctr.sv
module drs_pend_ctr #(
  parameter int MAX_PENDING = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic dec_req,
  output logic nonzero,
  output logic limit_hit
);
  localparam int PW = $clog2(MAX_PENDING + 1);
  localparam logic [PW-1:0] EDGE_VAL = PW'(MAX_PENDING - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic          dec;

  assign nonzero   = (cnt_q != '0);
  assign dec       = dec_req && nonzero;
  assign limit_hit = inc && !dec && (cnt_q == EDGE_VAL);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)              cnt_d = '0;
    else if (inc && !dec) cnt_d = cnt_q + 1'b1;
    else if (dec && !inc) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import drs_pkg::*;
#(
  parameter int CLK_KHZ     = 125000,
  parameter int ROW_BITS    = 12,
  parameter int POWERUP_US  = 200,
  parameter int WAKE_CYCLES = 8,
  parameter int MARGIN_CLKS = 16,
  parameter int MAX_PENDING = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_req,
  output logic mem_ready,
  output logic overdue
);
  localparam int ROWS        = 1 << ROW_BITS;
  localparam int RET_MS      = retention_ms(ROW_BITS);
  localparam int PERIOD_CLKS = (CLK_KHZ * RET_MS) / ROWS - MARGIN_CLKS;
  localparam int PAUSE_CLKS  = (POWERUP_US * CLK_KHZ) / 1000;
  localparam int WW          = $clog2(WAKE_CYCLES + 1);
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYCLES - 1);

  logic       srst_n;
  drs_state_e state_q, state_d;
  logic [WW-1:0] wake_q, wake_d;
  logic       overdue_q, overdue_d;
  logic       pause_tick;
  logic       period_tick;
  logic       pend_nz;
  logic       pend_hit;
  logic       in_pause, in_wake, in_run;

  assign in_pause = (state_q == ST_PAUSE);
  assign in_wake  = (state_q == ST_WAKE);
  assign in_run   = (state_q == ST_RUN);

  drs_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  drs_timer #(.LIMIT(PAUSE_CLKS)) u_pause_tmr (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (in_pause),
    .clr   (1'b0),
    .tick  (pause_tick)
  );

  drs_timer #(.LIMIT(PERIOD_CLKS)) u_period_tmr (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (in_run),
    .clr   (!in_run),
    .tick  (period_tick)
  );

  drs_pend_ctr #(.MAX_PENDING(MAX_PENDING)) u_pend (
    .clk       (clk),
    .rst_n     (srst_n),
    .clr       (!in_run),
    .inc       (period_tick),
    .dec_req   (ref_ack),
    .nonzero   (pend_nz),
    .limit_hit (pend_hit)
  );

  always_comb begin
    state_d   = state_q;
    wake_d    = wake_q;
    overdue_d = 1'b0;
    case (state_q)
      ST_PAUSE: begin
        wake_d = '0;
        if (pause_tick) state_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (ref_ack) begin
          if (wake_q == WAKE_LAST) state_d = ST_RUN;
          else                     wake_d  = wake_q + 1'b1;
        end
      end
      ST_RUN: begin
        wake_d = '0;
        if (pend_hit) begin
          state_d   = ST_WAKE;
          overdue_d = 1'b1;
        end
      end
      default: begin
        state_d = ST_PAUSE;
        wake_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q   <= ST_PAUSE;
      wake_q    <= '0;
      overdue_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      wake_q    <= wake_d;
      overdue_q <= overdue_d;
    end
  end

  assign ref_req   = in_wake || (in_run && pend_nz);
  assign mem_ready = in_run;
  assign overdue   = overdue_q;
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int PAUSE_CLKS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic ref_ack,
  input logic ref_req,
  input logic mem_ready,
  input logic overdue
);
  localparam int CW = $clog2(PAUSE_CLKS + 2);
  logic [CW-1:0] since_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst_q <= '0;
    else if (since_rst_q != CW'(PAUSE_CLKS)) since_rst_q <= since_rst_q + 1'b1;
  end

  AST_QUIET_DURING_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q < CW'(PAUSE_CLKS)) |-> (!ref_req && !mem_ready)); // R1

  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> $past(ref_ack)); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req); // R4

  AST_OVERDUE_REINIT: assert property (@(posedge clk) disable iff (!rst_n)
    overdue |-> (!mem_ready && ref_req)); // R7

  AST_OVERDUE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    overdue |=> !overdue); // R7
endmodule

bind dram_refresh_sched drs_checker #(.PAUSE_CLKS(PAUSE_CLKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_ack   (ref_ack),
  .ref_req   (ref_req),
  .mem_ready (mem_ready),
  .overdue   (overdue)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int CLK_KHZ  = 125000;
  localparam int ROW_BITS = 12;
  localparam int MARGIN   = 16;
  localparam int MAX_PEND = 4;
  localparam int WAKE_N   = 8;
  localparam int PAUSE    = (200 * CLK_KHZ) / 1000;
  localparam int PERIOD   = (CLK_KHZ * 64) / 4096 - MARGIN;

  // {cycles to wait, acks to give, expected ref_req, requirement number}
  localparam int TBL [7][4] = '{
    '{0,      1, 0, 4},  // R4 single ack retires the one owed refresh
    '{0,      1, 0, 6},  // R6 ack with nothing owed
    '{PERIOD, 0, 1, 3},  // R3 next expiry raises request
    '{PERIOD, 1, 1, 5},  // R5 two owed, one retired, still requesting
    '{0,      1, 0, 5},  // R5 second ack clears
    '{PERIOD, 0, 1, 6},  // R6 count did not wrap after idle ack
    '{0,      1, 0, 4}   // R4
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ref_ack;
  logic ref_req;
  logic mem_ready;
  logic overdue;

  int checks = 0;
  int failures = 0;
  int ovd_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_refresh_sched #(
    .CLK_KHZ(CLK_KHZ), .ROW_BITS(ROW_BITS), .POWERUP_US(200),
    .WAKE_CYCLES(WAKE_N), .MARGIN_CLKS(MARGIN), .MAX_PENDING(MAX_PEND)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack),
    .ref_req(ref_req), .mem_ready(mem_ready), .overdue(overdue)
  );

  always @(posedge clk) if (overdue) ovd_seen++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack_pulse();
    ref_ack = 1'b1;
    step();
    ref_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    ref_ack = 1'b0;
    repeat (3) step();
    check(ref_req == 1'b0, "R1 reset req", ref_req, 0);
    check(mem_ready == 1'b0, "R8 reset ready", mem_ready, 0);
    rst_n = 1'b1;

    // R1 pause length, with an ignored ack in the middle (R6)
    n = 0;
    while (!ref_req && n < PAUSE + 20) begin
      ref_ack = (n == 100);
      step();
      n++;
    end
    ref_ack = 1'b0;
    check(n == PAUSE + 2, "R1 pause edges", n, PAUSE + 2);

    // R2 / R8 wake-up: seven acks are not enough
    for (int i = 0; i < WAKE_N - 1; i++) ack_pulse();
    check(mem_ready == 1'b0, "R8 ready during wake", mem_ready, 0);
    check(ref_req == 1'b1, "R2 req held in wake", ref_req, 1);
    ack_pulse();
    check(mem_ready == 1'b1, "R2 ready after last ack", mem_ready, 1);
    check(ref_req == 1'b0, "R2 nothing owed", ref_req, 0);

    // R3 first period
    n = 0;
    while (!ref_req && n < PERIOD + 20) begin step(); n++; end
    check(n == PERIOD, "R3 period edges", n, PERIOD);

    // Table walk, starting right after an expiry edge
    for (int e = 0; e < 7; e++) begin
      repeat (TBL[e][0]) step();
      for (int a = 0; a < TBL[e][1]; a++) ack_pulse();
      checks++;
      if (ref_req != TBL[e][2][0] || !mem_ready) begin
        failures++;
        $display("FAIL R%0d table row %0d actual=%0d expected=%0d",
                 TBL[e][3], e, ref_req, TBL[e][2]);
      end
    end

    // R7 overdue: sync on next expiry, then withhold acks
    n = 0;
    while (!ref_req && n < PERIOD + 20) begin step(); n++; end
    check(ref_req == 1'b1, "R3 periodic request", ref_req, 1);
    repeat (2 * PERIOD + PERIOD - 5) step();
    check(mem_ready == 1'b1, "R7 not overdue yet", mem_ready, 1);
    check(ovd_seen == 0, "R7 no early pulse", ovd_seen, 0);
    repeat (10) step();
    check(mem_ready == 1'b0, "R7 ready dropped", mem_ready, 0);
    check(ref_req == 1'b1, "R7 wake request", ref_req, 1);
    check(ovd_seen == 1, "R7 single overdue pulse", ovd_seen, 1);
    for (int i = 0; i < WAKE_N - 1; i++) ack_pulse();
    check(mem_ready == 1'b0, "R7 re-wake incomplete", mem_ready, 0);
    ack_pulse();
    check(mem_ready == 1'b1, "R7 ready after re-wake", mem_ready, 1);
    n = 0;
    while (!ref_req && n < PERIOD + 20) begin step(); n++; end
    check(n == PERIOD, "R3 period after re-wake", n, PERIOD);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule